// File: doc/BRIEF.md
# Shared-Block Broadcast Destination Predictor

This block sits next to a node's second-level cache and decides, for each outgoing coherence request, where the request should go. It can send the request to every node, or only to the minimal set: the node that is home for the address plus the requesting node itself. Each table entry keeps a small saturating counter. The counter rises when the node sees sharing, meaning data supplied by a peer cache or a request from another node. It falls when data comes back from memory. A high counter selects a broadcast and a low counter, or no entry at all, selects the minimal set.

The table is direct-mapped and tagged. It is indexed by macroblock address, so neighbouring blocks inside one macroblock share a single entry. A lookup returns a destination bitmask one cycle after it is issued. Training events come in on a separate port and take effect at the same clock edge. The node count, entry count, address width and macroblock size are parameters.

Top module: `bcast_dest_pred`

## Requirements
- R1: While reset is asserted and after it is released, `pred_valid_o` is low and every table entry is invalid, so any lookup before training returns the minimal set.
- R2: `pred_valid_o` is high exactly one cycle after a cycle with `lkp_valid_i` high. `pred_mask_o` is all zeros whenever `pred_valid_o` is low.
- R3: On a lookup miss the mask has bit `self_id_i` set and bit `home` set, and no other bit. Here `home` = (address >> log2(MBLK_BYTES)) mod NODES. With the defaults (64-byte macroblocks, 16 nodes) this is address bits [9:6].
- R4: On a lookup hit the mask is all ones when the entry counter is 2 or 3, and the minimal set of R3 when the counter is 0 or 1.
- R5: Training kinds are encoded as follows: 0 = own response with data from memory (counter minus one), 1 = own response with data from a peer cache (counter plus one), 2 = request from another node observed (counter plus one), 3 = no effect on the table.
- R6: The 2-bit counter saturates at 3 on increments and at 0 on decrements.
- R7: A training event of kind 0, 1 or 2 that misses allocates the entry and replaces any earlier tag. The new counter starts at 1 and then takes the update, so it becomes 2 after an increment and 0 after a decrement.
- R8: A lookup that misses changes no table state. An entry already present at that index keeps its tag and counter.
- R9: When a lookup and a training event reach the same entry in the same cycle, the lookup returns the prediction from the counter and tag as they were before that update.
- R10: The index is the low log2(ENTRIES) bits of the macroblock number and the tag is the remaining upper bits. Addresses that differ only below the macroblock size share one entry. Two macroblocks with the same index but different tags displace each other.
- R11: When the home node equals `self_id_i`, a minimal-set mask has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| self_id_i | input | NID_W | Identifier of this node (held static) |
| lkp_valid_i | input | 1 | Prediction lookup request |
| lkp_addr_i | input | ADDR_W | Byte address of the outgoing request |
| trn_valid_i | input | 1 | Training event valid |
| trn_addr_i | input | ADDR_W | Byte address of the training event |
| trn_kind_i | input | 2 | Training kind, encoded as in R5 |
| pred_valid_o | output | 1 | Prediction valid, one cycle after lookup |
| pred_mask_o | output | NODES | Destination bitmask, one bit per node |

## Verification
Some properties are checked on every cycle. These are the one-cycle lookup-to-result timing, the zero mask when no prediction is valid, the presence of the requester's own bit, and the rule that a mask is either full or has at most two bits set. Inside the table, checks confirm that a missing training event installs its tag with a counter of 2 or 0 and that the counter holds at its upper limit. Other behaviour only shows up across a sequence of events, so the bench scenarios cover it. These cases are counter saturation at both ends, kind 3 being ignored, a lookup miss leaving a conflicting entry in place, macroblock aliasing, and a lookup seeing the pre-update value when it collides with training.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    TRN_MEM   = 2'd0,
    TRN_PEER  = 2'd1,
    TRN_SNOOP = 2'd2,
    TRN_NONE  = 2'd3
  } trn_kind_e;

  localparam logic [1:0] CNT_ALLOC = 2'd1;
  localparam logic [1:0] CNT_MAX   = 2'd3;
  localparam logic [1:0] CNT_THR   = 2'd1;

  function automatic logic [1:0] sat_step(input logic [1:0] cnt, input logic up);
    if (up) return (cnt == CNT_MAX) ? CNT_MAX : cnt + 2'd1;
    else    return (cnt == 2'd0)    ? 2'd0    : cnt - 2'd1;
  endfunction

endpackage

// File: rtl/bdp_addr_split.sv
module bdp_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int MBLK_BYTES = 64,
  parameter int ENTRIES    = 256,
  parameter int NODES      = 16,
  localparam int OFF_W = $clog2(MBLK_BYTES),
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int MB_W  = ADDR_W - OFF_W,
  localparam int TAG_W = MB_W - IDX_W,
  localparam int NID_W = $clog2(NODES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [NID_W-1:0]  home_o
);

  logic [MB_W-1:0] mblk;
  logic            unused_off;

  assign mblk       = addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^addr_i[OFF_W-1:0];
  assign idx_o      = mblk[IDX_W-1:0];
  assign tag_o      = mblk[MB_W-1:IDX_W];
  assign home_o     = NID_W'(mblk % MB_W'(NODES));

endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  output logic [1:0]       rd_cnt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_up_i
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [1:0]         cnt_q [ENTRIES];

  logic       wr_hit;
  logic [1:0] wr_cnt;
  logic [1:0] wr_base;

  // read side sees state before this edge's write
  assign rd_hit_o = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_cnt_o = cnt_q[rd_idx_i];

  assign wr_hit  = vld_q[wr_idx_i] && (tag_q[wr_idx_i] == wr_tag_i);
  assign wr_cnt  = cnt_q[wr_idx_i];
  assign wr_base = wr_hit ? wr_cnt : CNT_ALLOC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i] <= wr_tag_i;
      cnt_q[wr_idx_i] <= sat_step(wr_base, wr_up_i);
    end
  end

  // R7
  alloc_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit) |=> (vld_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)));

  // R7
  alloc_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit) |=> (cnt_q[$past(wr_idx_i)] == ($past(wr_up_i) ? 2'd2 : 2'd0)));

  // R6
  cnt_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hit && wr_up_i && wr_cnt == CNT_MAX) |=> (cnt_q[$past(wr_idx_i)] == CNT_MAX));

  // R6
  cnt_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hit && !wr_up_i && wr_cnt == 2'd0) |=> (cnt_q[$past(wr_idx_i)] == 2'd0));

endmodule

// File: rtl/bdp_mask_gen.sv
module bdp_mask_gen
  import bdp_pkg::*;
#(
  parameter int NODES  = 16,
  localparam int NID_W = $clog2(NODES)
) (
  input  logic             hit_i,
  input  logic [1:0]       cnt_i,
  input  logic [NID_W-1:0] home_i,
  input  logic [NID_W-1:0] self_i,
  output logic [NODES-1:0] mask_o
);

  logic [NODES-1:0] min_set;

  always_comb begin
    min_set         = '0;
    min_set[home_i] = 1'b1;
    min_set[self_i] = 1'b1;
  end

  assign mask_o = (hit_i && cnt_i > CNT_THR) ? '1 : min_set;

endmodule

// File: rtl/bcast_dest_pred.sv
module bcast_dest_pred
  import bdp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NODES      = 16,
  parameter int ENTRIES    = 256,
  parameter int MBLK_BYTES = 64,
  localparam int NID_W = $clog2(NODES),
  localparam int OFF_W = $clog2(MBLK_BYTES),
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NID_W-1:0]  self_id_i,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              trn_valid_i,
  input  logic [ADDR_W-1:0] trn_addr_i,
  input  logic [1:0]        trn_kind_i,
  output logic              pred_valid_o,
  output logic [NODES-1:0]  pred_mask_o
);

  logic [IDX_W-1:0] lkp_idx, trn_idx;
  logic [TAG_W-1:0] lkp_tag, trn_tag;
  logic [NID_W-1:0] lkp_home, trn_home;
  logic             rd_hit;
  logic [1:0]       rd_cnt;
  logic             wr_en, wr_up;
  logic [NODES-1:0] mask_d;
  logic             unused_trn_home;
  trn_kind_e        kind;

  bdp_addr_split #(
    .ADDR_W(ADDR_W), .MBLK_BYTES(MBLK_BYTES), .ENTRIES(ENTRIES), .NODES(NODES)
  ) i_lkp_split (
    .addr_i(lkp_addr_i), .idx_o(lkp_idx), .tag_o(lkp_tag), .home_o(lkp_home)
  );

  bdp_addr_split #(
    .ADDR_W(ADDR_W), .MBLK_BYTES(MBLK_BYTES), .ENTRIES(ENTRIES), .NODES(NODES)
  ) i_trn_split (
    .addr_i(trn_addr_i), .idx_o(trn_idx), .tag_o(trn_tag), .home_o(trn_home)
  );

  assign unused_trn_home = ^trn_home;

  assign kind  = trn_kind_e'(trn_kind_i);
  assign wr_en = trn_valid_i && (kind != TRN_NONE);
  assign wr_up = (kind != TRN_MEM);

  bdp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lkp_idx),
    .rd_tag_i (lkp_tag),
    .rd_hit_o (rd_hit),
    .rd_cnt_o (rd_cnt),
    .wr_en_i  (wr_en),
    .wr_idx_i (trn_idx),
    .wr_tag_i (trn_tag),
    .wr_up_i  (wr_up)
  );

  bdp_mask_gen #(.NODES(NODES)) i_mask (
    .hit_i  (rd_hit),
    .cnt_i  (rd_cnt),
    .home_i (lkp_home),
    .self_i (self_id_i),
    .mask_o (mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_mask_o  <= '0;
    end else begin
      pred_valid_o <= lkp_valid_i;
      pred_mask_o  <= lkp_valid_i ? mask_d : '0;
    end
  end

  // R2
  lkp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> pred_valid_o);

  // R2
  idle_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> (!pred_valid_o && pred_mask_o == '0));

  // R3
  self_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> pred_mask_o[self_id_i]);

  // R4
  mask_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> ((&pred_mask_o) || ($countones(pred_mask_o) <= 2)));

endmodule

// File: tb/test_bcast_dest_pred.sv
`timescale 1ns/1ps
module test_bcast_dest_pred;

  localparam int NODES = 16;
  localparam int AW    = 32;
  localparam logic [3:0] SELF = 4'd5;

  localparam logic [31:0] A = 32'h0000_44C0; // idx 0x13 tag 1, home 3
  localparam logic [31:0] B = 32'h0000_84C0; // idx 0x13 tag 2, home 3
  localparam logic [31:0] C = 32'h0000_4140; // idx 0x05, home 5 == self
  localparam logic [31:0] D = 32'h0000_FE80; // idx 0xFA tag 3, home 10
  localparam logic [31:0] E = 32'h0000_4800; // idx 0x20 tag 1, home 0

  typedef struct packed {
    logic        trn;
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        bc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  // kinds: 0 mem, 1 peer, 2 foreign request, 3 none
  localparam vec_t VECS [NV] = '{
    '{1'b0, A,         2'd0, 1'b0, 8'd3 },  // R3 empty table
    '{1'b1, A,         2'd1, 1'b0, 8'd7 },  // R7 alloc -> 2
    '{1'b0, A,         2'd0, 1'b1, 8'd7 },
    '{1'b1, A,         2'd0, 1'b0, 8'd5 },  // R5 -> 1
    '{1'b0, A,         2'd0, 1'b0, 8'd4 },  // R4 cnt 1
    '{1'b1, A,         2'd2, 1'b0, 8'd5 },  // R5 -> 2
    '{1'b0, A,         2'd0, 1'b1, 8'd5 },
    '{1'b1, A,         2'd2, 1'b0, 8'd6 },  // -> 3
    '{1'b1, A,         2'd1, 1'b0, 8'd6 },  // R6 stays 3
    '{1'b1, A,         2'd0, 1'b0, 8'd6 },  // -> 2
    '{1'b1, A,         2'd0, 1'b0, 8'd6 },  // -> 1
    '{1'b0, A,         2'd0, 1'b0, 8'd6 },
    '{1'b1, A,         2'd0, 1'b0, 8'd6 },  // -> 0
    '{1'b1, A,         2'd0, 1'b0, 8'd6 },  // R6 stays 0
    '{1'b1, A,         2'd1, 1'b0, 8'd6 },  // -> 1
    '{1'b1, A,         2'd1, 1'b0, 8'd6 },  // -> 2
    '{1'b0, A,         2'd0, 1'b1, 8'd6 },
    '{1'b1, A,         2'd3, 1'b0, 8'd5 },  // R5 kind 3 ignored
    '{1'b0, A,         2'd0, 1'b1, 8'd5 },
    '{1'b0, A | 32'h3F,2'd0, 1'b1, 8'd10},  // R10 same macroblock
    '{1'b0, B,         2'd0, 1'b0, 8'd8 },  // R8 conflict miss
    '{1'b0, A,         2'd0, 1'b1, 8'd8 },  // R8 A untouched
    '{1'b1, B,         2'd0, 1'b0, 8'd10},  // R10 B displaces A, cnt 0
    '{1'b0, A,         2'd0, 1'b0, 8'd10},
    '{1'b0, B,         2'd0, 1'b0, 8'd10},
    '{1'b0, C,         2'd0, 1'b0, 8'd11},  // R11 single bit
    '{1'b1, D,         2'd1, 1'b0, 8'd7 },
    '{1'b0, D,         2'd0, 1'b1, 8'd4 },  // R4 cnt 2
    '{1'b0, D | 32'h21,2'd0, 1'b1, 8'd10}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lkp_valid_i = 1'b0;
  logic [AW-1:0]    lkp_addr_i = '0;
  logic             trn_valid_i = 1'b0;
  logic [AW-1:0]    trn_addr_i = '0;
  logic [1:0]       trn_kind_i = '0;
  logic             pred_valid_o;
  logic [NODES-1:0] pred_mask_o;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #2 clk_i = ~clk_i;

  bcast_dest_pred i_bcast_dest_pred (
    .clk_i, .rst_ni, .self_id_i(SELF),
    .lkp_valid_i, .lkp_addr_i,
    .trn_valid_i, .trn_addr_i, .trn_kind_i,
    .pred_valid_o, .pred_mask_o
  );

  function automatic logic [NODES-1:0] exp_mask(input logic [31:0] a, input logic bc);
    logic [NODES-1:0] m;
    if (bc) return '1;
    m = '0;
    m[(a >> 6) % NODES] = 1'b1;
    m[SELF] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic ok,
                       input logic [NODES:0] act, input logic [NODES:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic bc, input string req);
    logic [NODES-1:0] e;
    e = exp_mask(a, bc);
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_addr_i = a;
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
    check(req, pred_valid_o && pred_mask_o == e, {pred_valid_o, pred_mask_o}, {1'b1, e});
  endtask

  task automatic train(input logic [31:0] a, input logic [1:0] k);
    @(negedge clk_i);
    trn_valid_i = 1'b1; trn_addr_i = a; trn_kind_i = k;
    @(negedge clk_i);
    trn_valid_i = 1'b0;
  endtask

  task automatic both(input logic [31:0] a, input logic [1:0] k, input logic bc, input string req);
    logic [NODES-1:0] e;
    e = exp_mask(a, bc);
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_addr_i = a;
    trn_valid_i = 1'b1; trn_addr_i = a; trn_kind_i = k;
    @(negedge clk_i);
    lkp_valid_i = 1'b0; trn_valid_i = 1'b0;
    check(req, pred_valid_o && pred_mask_o == e, {pred_valid_o, pred_mask_o}, {1'b1, e});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", !pred_valid_o && pred_mask_o == '0, {pred_valid_o, pred_mask_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", !pred_valid_o && pred_mask_o == '0, {pred_valid_o, pred_mask_o}, '0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].trn) train(VECS[i].addr, VECS[i].kind);
      else lookup(VECS[i].addr, VECS[i].bc, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R2 idle cycle after a lookup
    @(negedge clk_i);
    check("R2", !pred_valid_o && pred_mask_o == '0, {pred_valid_o, pred_mask_o}, '0);

    // R9 collision: lookup sees pre-update state
    both(E, 2'd1, 1'b0, "R9 miss before alloc");
    lookup(E, 1'b1, "R9 after alloc");
    both(E, 2'd0, 1'b1, "R9 hit before dec");
    lookup(E, 1'b0, "R9 after dec");

    // R1 reset mid-run clears table
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", !pred_valid_o && pred_mask_o == '0, {pred_valid_o, pred_mask_o}, '0);
    rst_ni = 1'b1;
    lookup(D, 1'b0, "R1 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule